// File: doc/BRIEF.md
# Dual-Clock FIFO with Registered Read Port

This block buffers a stream of words between two clock domains whose clocks have no fixed phase or frequency relationship. Words are written into a dual-port storage array from the write clock and read out of the same array from the read clock, so the data itself never passes through a synchronizer. Only the write and read positions move between domains. Each is kept as a binary counter, turned into Gray code in its home domain, and sampled by two flops in the other domain.

The read port is registered. A pop accepted on one read-clock edge places the word on `rd_data` after that same edge, and `rd_valid` is high for exactly that read-clock cycle. This lets the storage map onto synchronous block memory. Both status flags are registers loaded from a comparison against the next pointer value. Full therefore rises right after the write that takes the last slot, and empty rises right after the pop that takes the last word. The flags may be held longer than strictly needed, because the pointer seen from the other domain is a few cycles old. No word is ever lost or delivered twice. The depth is always a power of two.

Top module: `dcf_fifo`

## Requirements
- R1: Every accepted word is delivered on `rd_data` exactly once, in the order it was written, with its value unchanged.
- R2: Each side has its own synchronous active-high reset. After reset, `rd_empty` is 1, `wr_full` is 0 and `rd_valid` is 0, and no word written before the reset is delivered.
- R3: A write is taken on a rising `wr_clk` edge only when `wr_en` is 1 and `wr_full` is 0. An empty FIFO with no reads accepts exactly 2^ADDR_W writes, and writes attempted while full are dropped.
- R4: A read is taken on a rising `rd_clk` edge only when `rd_en` is 1 and `rd_empty` is 0. Read requests while empty produce no `rd_valid`.
- R5: The word for a read accepted on a `rd_clk` edge is on `rd_data` with `rd_valid` = 1 during the following read-clock cycle. `rd_valid` is 0 in every cycle that does not follow an accepted read.
- R6: `wr_full` is 1 right after the edge that accepts the write filling the last free slot, and it is 1 whenever the write side's view of the occupancy equals the depth.
- R7: With no writes in progress, `rd_empty` is 1 right after the edge that accepts the read of the last stored word, and it is 1 whenever the read side's view of the occupancy is zero.
- R8: Each pointer that crosses between domains changes by at most one bit per edge of its own clock (Gray code).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Write-side synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| wr_full | output | 1 | No free slot; writes are dropped |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Read-side synchronous reset, active high |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered read word |
| rd_valid | output | 1 | `rd_data` holds a freshly popped word this cycle |
| rd_empty | output | 1 | No stored word; reads are ignored |

## Verification
The occupancy properties assume that both resets are applied together and held across several edges of both clocks. Otherwise one domain's view of the other pointer would be left stale from before the reset. The bench always raises and releases both resets as a pair, holding them longer than the slower clock's period. It also changes `wr_en`, `wr_data` and `rd_en` only on falling edges, so every request is stable at the sampling edge. The two clocks run at unrelated periods, so the phase between the domains keeps shifting across the fill, drain and mixed-rate sweeps.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

    // Widest pointer the helper functions handle.
    localparam int PTR_MAX_W = 31;

    // Binary to reflected Gray code.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary: running XOR from the top bit down.
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
// Two-stage synchronizer for a bus that changes at most one bit at a time.
module dcf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/dcf_wr_ctrl.sv
`timescale 1ns/1ps
// Write-side pointer and registered full flag.
module dcf_wr_ctrl #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_s,
    output logic          wr_ok,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output logic          full
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } ptr_t;

    ptr_t          cur_q;
    ptr_t          nxt;
    logic          full_q;
    logic [PW-1:0] full_pattern;

    assign wr_ok    = wr_en && !full_q;
    assign nxt.bin  = cur_q.bin + PW'(wr_ok);
    assign nxt.gray = PW'(dcf_pkg::to_gray(32'(nxt.bin)));

    // One wrap ahead of the read side: top two Gray bits differ, rest equal.
    assign full_pattern = {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            full_q <= 1'b0;
        end else begin
            cur_q  <= nxt;
            full_q <= (nxt.gray == full_pattern);
        end
    end

    assign waddr = cur_q.bin[AW-1:0];
    assign wbin  = cur_q.bin;
    assign wgray = cur_q.gray;
    assign full  = full_q;
endmodule

// File: rtl/dcf_rd_ctrl.sv
`timescale 1ns/1ps
// Read-side pointer and registered empty flag.
module dcf_rd_ctrl #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_s,
    output logic          rd_ok,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic          empty
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } ptr_t;

    ptr_t cur_q;
    ptr_t nxt;
    logic empty_q;

    assign rd_ok    = rd_en && !empty_q;
    assign nxt.bin  = cur_q.bin + PW'(rd_ok);
    assign nxt.gray = PW'(dcf_pkg::to_gray(32'(nxt.bin)));

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            empty_q <= 1'b1;
        end else begin
            cur_q   <= nxt;
            empty_q <= (nxt.gray == wgray_s);
        end
    end

    assign raddr = cur_q.bin[AW-1:0];
    assign rbin  = cur_q.bin;
    assign rgray = cur_q.gray;
    assign empty = empty_q;
endmodule

// File: rtl/dcf_mem.sv
`timescale 1ns/1ps
// Dual-port storage: write port on one clock, registered read port on the other.
module dcf_mem #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Data register carries no reset so it maps onto a block-memory output.
    always_ff @(posedge rd_clk) begin
        if (re) begin
            rdata <= store[raddr];
        end
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rvalid <= 1'b0;
        end else begin
            rvalid <= re;
        end
    end
endmodule

// File: rtl/dcf_fifo.sv
`timescale 1ns/1ps
// Dual-clock FIFO, Gray-coded pointer crossing, registered read port.
module dcf_fifo #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_empty
);
    localparam int PW = ADDR_W + 1;

    if (ADDR_W < 2 || PW > dcf_pkg::PTR_MAX_W) begin : g_bad_addr_w
        $error("dcf_fifo: ADDR_W must lie between 2 and %0d", dcf_pkg::PTR_MAX_W - 1);
    end

    logic              wr_ok;
    logic              rd_ok;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [PW-1:0]     wbin;
    logic [PW-1:0]     wgray;
    logic [PW-1:0]     rbin;
    logic [PW-1:0]     rgray;
    logic [PW-1:0]     rgray_ws;   // read pointer seen in write domain
    logic [PW-1:0]     wgray_rs;   // write pointer seen in read domain

    dcf_wr_ctrl #(.AW(ADDR_W)) u_wr (
        .clk     (wr_clk),
        .rst     (wr_rst),
        .wr_en   (wr_en),
        .rgray_s (rgray_ws),
        .wr_ok   (wr_ok),
        .waddr   (waddr),
        .wbin    (wbin),
        .wgray   (wgray),
        .full    (wr_full)
    );

    dcf_rd_ctrl #(.AW(ADDR_W)) u_rd (
        .clk     (rd_clk),
        .rst     (rd_rst),
        .rd_en   (rd_en),
        .wgray_s (wgray_rs),
        .rd_ok   (rd_ok),
        .raddr   (raddr),
        .rbin    (rbin),
        .rgray   (rgray),
        .empty   (rd_empty)
    );

    dcf_sync #(.W(PW)) u_sync_r2w (
        .clk (wr_clk),
        .rst (wr_rst),
        .d   (rgray),
        .q   (rgray_ws)
    );

    dcf_sync #(.W(PW)) u_sync_w2r (
        .clk (rd_clk),
        .rst (rd_rst),
        .d   (wgray),
        .q   (wgray_rs)
    );

    dcf_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .wr_clk (wr_clk),
        .we     (wr_ok),
        .waddr  (waddr),
        .wdata  (wr_data),
        .rd_clk (rd_clk),
        .rd_rst (rd_rst),
        .re     (rd_ok),
        .raddr  (raddr),
        .rdata  (rd_data),
        .rvalid (rd_valid)
    );
endmodule

// File: rtl/dcf_fifo_chk.sv
`timescale 1ns/1ps
// Property checker for dcf_fifo, attached by bind.
module dcf_fifo_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input logic              wr_clk,
    input logic              wr_rst,
    input logic              wr_full,
    input logic              rd_clk,
    input logic              rd_rst,
    input logic              rd_en,
    input logic              rd_valid,
    input logic              rd_empty,
    input logic [ADDR_W:0]   wbin,
    input logic [ADDR_W:0]   wgray,
    input logic [ADDR_W:0]   rbin,
    input logic [ADDR_W:0]   rgray,
    input logic [ADDR_W:0]   rgray_ws,
    input logic [ADDR_W:0]   wgray_rs
);
    localparam int            PW    = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH = PW'(1 << ADDR_W);

    logic [PW-1:0] rbin_w;
    logic [PW-1:0] wbin_r;
    logic [PW-1:0] occ_w;
    logic [PW-1:0] occ_r;

    assign rbin_w = PW'(dcf_pkg::from_gray(32'(rgray_ws)));
    assign wbin_r = PW'(dcf_pkg::from_gray(32'(wgray_rs)));
    assign occ_w  = wbin - rbin_w;
    assign occ_r  = wbin_r - rbin;

    // R3: write side never counts more than the depth
    a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (wr_rst)
        occ_w <= DEPTH);

    // R3: a full flag freezes the write pointer
    a_r3_full_blocks_write: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_full |=> $stable(wbin));

    // R6: no room left implies the flag is up
    a_r6_full_when_no_room: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (occ_w == DEPTH) |-> wr_full);

    // R4: read side never passes the write pointer
    a_r4_no_underflow: assert property (@(posedge rd_clk) disable iff (rd_rst)
        occ_r <= DEPTH);

    // R7: nothing visible to read implies empty
    a_r7_empty_when_drained: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (occ_r == '0) |-> rd_empty);

    // R5: accepted pop gives valid one cycle later
    a_r5_valid_follows_pop: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && !rd_empty) |=> rd_valid);

    // R5: no valid without an accepted pop
    a_r5_no_spurious_valid: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !(rd_en && !rd_empty) |=> !rd_valid);

    // R8: crossing pointers move one bit at a time
    a_r8_wgray_one_bit: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(wgray ^ $past(wgray)) <= 1);

    a_r8_rgray_one_bit: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $countones(rgray ^ $past(rgray)) <= 1);

    // R2: flags after a reset edge, checked away from the edge
    logic wr_rst_seen;
    logic rd_rst_seen;

    always_ff @(posedge wr_clk) wr_rst_seen <= wr_rst;
    always_ff @(posedge rd_clk) rd_rst_seen <= rd_rst;

    always @(negedge wr_clk) begin
        if (wr_rst_seen) begin
            a_r2_full_clear: assert (!wr_full);
        end
    end

    always @(negedge rd_clk) begin
        if (rd_rst_seen) begin
            a_r2_empty_set: assert (rd_empty && !rd_valid);
        end
    end
endmodule

bind dcf_fifo dcf_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .wr_clk   (wr_clk),
    .wr_rst   (wr_rst),
    .wr_full  (wr_full),
    .rd_clk   (rd_clk),
    .rd_rst   (rd_rst),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .rd_empty (rd_empty),
    .wbin     (wbin),
    .wgray    (wgray),
    .rbin     (rbin),
    .rgray    (rgray),
    .rgray_ws (rgray_ws),
    .wgray_rs (wgray_rs)
);

// File: tb/dcf_fifo_bench.sv
`timescale 1ns/1ps
module dcf_fifo_bench;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          wr_clk  = 1'b0;
    logic          rd_clk  = 1'b0;
    logic          wr_rst  = 1'b1;
    logic          rd_rst  = 1'b1;
    logic          wr_en   = 1'b0;
    logic          rd_en   = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_full;
    logic          rd_empty;
    logic          rd_valid;
    logic [DW-1:0] rd_data;

    int            checks = 0;
    int            errors = 0;
    int            pops   = 0;
    int            rd_pct = 0;
    bit            quiet  = 1'b1;
    bit            ended  = 1'b0;
    logic [DW-1:0] model[$];

    always #2   wr_clk = ~wr_clk;   // 250 MHz
    always #3.5 rd_clk = ~rd_clk;   // unrelated read clock

    dcf_fifo #(.DATA_W(DW), .ADDR_W(AW)) u_dcf_fifo (
        .wr_clk   (wr_clk),
        .wr_rst   (wr_rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_full  (wr_full),
        .rd_clk   (rd_clk),
        .rd_rst   (rd_rst),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .rd_empty (rd_empty)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Reader: checks each read-clock cycle, then drives the next request.
    initial begin
        bit exp_v;
        exp_v = 1'b0;
        forever begin
            @(negedge rd_clk);
            if (rd_rst) begin
                exp_v = 1'b0;
                rd_en = 1'b0;
            end else begin
                check(rd_valid == exp_v, "R5", "rd_valid", int'(rd_valid), int'(exp_v));
                if (rd_valid) begin
                    if (model.size() == 0) begin
                        check(1'b0, "R1", "pop with nothing written", 1, 0);
                    end else begin
                        logic [DW-1:0] e;
                        e = model.pop_front();
                        check(rd_data == e, "R1", "rd_data", int'(rd_data), int'(e));
                        pops++;
                        if (quiet && model.size() == 0)
                            check(rd_empty == 1'b1, "R7", "empty after last pop",
                                  int'(rd_empty), 1);
                    end
                end
                rd_en = ($urandom_range(99) < rd_pct);
                exp_v = rd_en && !rd_empty;
            end
        end
    end

    task automatic apply_reset();
        wr_en  = 1'b0;
        wr_rst = 1'b1;
        rd_rst = 1'b1;
        repeat (4) @(negedge rd_clk);
        model.delete();
        @(negedge wr_clk);
        wr_rst = 1'b0;
        rd_rst = 1'b0;
        @(negedge rd_clk);
        @(negedge wr_clk);
        check(wr_full == 1'b0, "R2", "wr_full after reset", int'(wr_full), 0);
        check(rd_empty == 1'b1, "R2", "rd_empty after reset", int'(rd_empty), 1);
        check(rd_valid == 1'b0, "R2", "rd_valid after reset", int'(rd_valid), 0);
    endtask

    task automatic wr_phase(input int cycles, input int pct);
        quiet = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge wr_clk);
            wr_en   = ($urandom_range(99) < pct);
            wr_data = DW'($urandom);
            if (wr_en && !wr_full) model.push_back(wr_data);
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic drain(input string req);
        rd_pct = 100;
        repeat (10) @(negedge rd_clk);
        quiet = 1'b1;
        for (int i = 0; i < 400 && model.size() != 0; i++) @(negedge rd_clk);
        check(model.size() == 0, req, "words left undelivered", model.size(), 0);
        repeat (4) @(negedge rd_clk);
        check(rd_empty == 1'b1, "R7", "empty once drained", int'(rd_empty), 1);
    endtask

    initial begin
        #(200000 * 4);
        check(1'b0, "WATCHDOG", "run did not complete", 0, 1);
        finish_run();
    end

    initial begin
        int k;
        int base;
        apply_reset();

        // Fill with reads off: full timing and dropped writes.
        rd_pct = 0;
        quiet  = 1'b0;
        k      = 0;
        for (int i = 0; i < DEPTH + 8; i++) begin
            @(negedge wr_clk);
            if (i > 0)
                check(wr_full == (k == DEPTH), "R6", "wr_full vs writes taken",
                      int'(wr_full), int'(k == DEPTH));
            wr_en   = 1'b1;
            wr_data = DW'(8'h40 + i);
            if (!wr_full) begin
                model.push_back(wr_data);
                k++;
            end
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
        check(k == DEPTH, "R3", "writes accepted into empty FIFO", k, DEPTH);

        base = pops;
        drain("R1");
        check(pops - base == DEPTH, "R3", "words delivered after fill", pops - base, DEPTH);
        repeat (6) @(negedge wr_clk);
        check(wr_full == 1'b0, "R3", "wr_full after drain", int'(wr_full), 0);

        // Reads while empty.
        base = pops;
        repeat (20) @(negedge rd_clk);
        check(pops == base, "R4", "pops while empty", pops - base, 0);

        // Mixed-rate sweeps.
        rd_pct = 30;  wr_phase(800, 100); drain("R1");
        rd_pct = 100; wr_phase(800, 30);  drain("R1");
        rd_pct = 70;  wr_phase(800, 70);  drain("R1");
        rd_pct = 100; wr_phase(800, 100); drain("R1");
        rd_pct = 20;  wr_phase(800, 50);  drain("R1");

        // Reset with words stored: none may come out.
        rd_pct = 0;
        wr_phase(6, 100);
        repeat (6) @(negedge rd_clk);
        apply_reset();
        rd_pct = 100;
        base   = pops;
        repeat (20) @(negedge rd_clk);
        check(pops == base, "R2", "words delivered after reset", pops - base, 0);
        check(rd_empty == 1'b1, "R2", "rd_empty after reset with data", int'(rd_empty), 1);

        finish_run();
    end
endmodule